// File: doc/BRIEF.md
# Clock Generator Controller with Grouped Divider Updates

This block is the register-driven control side of an on-chip clock generator. A reference clock runs it. Through a simple write bus with a combinational read port, software sets the loop multiplier, an input divider, an output divider and a bank of output dividers. It also sets the control bits that govern bypass, loop reset, loop gating and power-down. The analog loop is not modelled. A lock state machine stands in for it: it counts reference cycles once the loop is released, and only after lock does the clock source leave bypass.

Software writes new output divider ratios into staging registers. Writing the start command snapshots all staged values. A sequencer is then busy for a fixed number of reference cycles and copies the snapshot into the active dividers on one common edge. Software polls the busy flag to see when the update is done.

The lock machine has four states. LK_OFF is entered while power-down is set. LK_HOLD is entered while reset or gating is set. LK_ACQ counts reference cycles toward lock. LK_LOCKED marks a settled loop. Transitions:
- Any state goes to LK_OFF on power-down, else to LK_HOLD on reset or gating.
- LK_OFF and LK_HOLD go to LK_ACQ once released.
- LK_ACQ goes to LK_LOCKED when its count expires.
- LK_ACQ and LK_LOCKED restart LK_ACQ when the multiplier changes.

The update sequencer has two states. GO_IDLE goes to GO_RUN on a start command. GO_RUN goes back to GO_IDLE when its countdown reaches zero.

Top module: `pllc_top`

## Requirements
- R1: After reset: control reads 0x0012 (power-down and gate set), multiplier reads 0, every output divider (staged and active) holds 0x8000, and lock, busy and source select are 0.
- R2: Control (byte address 0x100) stores enable bit 0, power-down bit 1, loop reset bit 3, gate bit 4, source select bit 5 and mode bit 8; all other bits read 0.
- R3: A write that sets loop reset (bit 3) when it was clear takes effect only if enable (bit 0) has been clear for at least BYPASS_MIN (4) cycles; otherwise bit 3 stays 0 and the rest of the write is stored.
- R4: With power-down, loop reset and gate all clear, lock rises LOCK_CYCLES (8000) reference cycles after release, within two cycles of pipeline delay.
- R5: Lock falls within two cycles when loop reset or power-down is set, or when the multiplier is written with a value different from the one it holds. A write of the same value leaves lock high.
- R6: The source select output is high only when enable is set and lock is high; otherwise the output stays in bypass.
- R7: The multiplier (0x110) keeps the low 8 bits. The input divider (0x114), output divider (0x128) and output dividers 0..3 (0x118, 0x11C, 0x160, 0x164) keep bit 15 (enable) and the low RATIO_W (5) bits; other bits read 0.
- R8: Writing 1 to bit 0 at 0x138 starts an update: status bit 0 (0x13C) reads 1 for exactly GO_CYCLES (16) cycles, and all active dividers take the snapshotted staged values on the edge where it clears.
- R9: A start command written while an update is running is ignored and does not lengthen it.
- R10: A divider write during a running update changes only its staging register and is applied by the next start command.
- R11: Active divider values never change except on the edge that ends an update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 12 | Byte address for read and write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| pll_lock | output | 1 | Modelled loop is locked |
| pll_selected | output | 1 | Clock source is the loop, not bypass |
| go_busy | output | 1 | Divider update running |
| div_active | output | NUM_OUT*16 | Active output divider values, divider i in bits [16i+15:16i] |

## Verification
Two events can land in the same cycle: a new start command or a divider write, and an update that is already counting down. The bench provokes this by writing in the third busy cycle, either a second start command or a fresh divider value. It then judges the result by the measured busy length and by the active values at the end. These must equal the snapshot taken at launch, and the late write must stay only in staging until the next update is applied. A multiplier rewrite while locked is paired with the same-value case to tell a real change from a mere write.

// File: rtl/pllc_pkg.sv
package pllc_pkg;
    typedef enum logic [1:0] {LK_OFF, LK_HOLD, LK_ACQ, LK_LOCKED} lk_state_e;
    typedef enum logic {GO_IDLE, GO_RUN} go_state_e;

    localparam int DIV_W = 16;
    localparam logic [11:0] A_CTRL = 12'h100;
    localparam logic [11:0] A_MULT = 12'h110;
    localparam logic [11:0] A_PRE  = 12'h114;
    localparam logic [11:0] A_POST = 12'h128;
    localparam logic [11:0] A_CMD  = 12'h138;
    localparam logic [11:0] A_STAT = 12'h13C;

    localparam int B_EN   = 0;
    localparam int B_PD   = 1;
    localparam int B_RST  = 3;
    localparam int B_GATE = 4;
    localparam logic [15:0] CTRL_MASK  = 16'h013B;
    localparam logic [15:0] CTRL_RESET = 16'h0012;
    localparam logic [15:0] DIV_RESET  = 16'h8000;

    function automatic logic [11:0] out_addr(input int idx);
        case (idx)
            0:       return 12'h118;
            1:       return 12'h11C;
            2:       return 12'h160;
            default: return 12'h164;
        endcase
    endfunction

    function automatic logic [15:0] div_mask(input int ratio_w);
        return 16'h8000 | 16'((32'd1 << ratio_w) - 1);
    endfunction
endpackage

// File: rtl/pllc_regs.sv
module pllc_regs
    import pllc_pkg::*;
#(
    parameter int RATIO_W    = 5,
    parameter int BYPASS_MIN = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [11:0] bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] ctrl_q,
    output logic [7:0]  mult_q,
    output logic [15:0] pre_q,
    output logic [15:0] post_q,
    output logic        mult_chg
);
    localparam int BC_W = $clog2(BYPASS_MIN + 1);
    localparam logic [15:0] DMASK = div_mask(RATIO_W);

    logic [BC_W-1:0] byp_cnt;
    logic [15:0]     ctrl_nx;

    // Settling counter: cycles spent with enable clear, saturating.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            byp_cnt <= '0;
        else if (ctrl_q[B_EN])
            byp_cnt <= '0;
        else if (byp_cnt < BC_W'(BYPASS_MIN))
            byp_cnt <= byp_cnt + 1'b1;
    end

    always_comb begin
        ctrl_nx = bus_wdata & CTRL_MASK;
        if (ctrl_nx[B_RST] && !ctrl_q[B_RST] && (byp_cnt < BC_W'(BYPASS_MIN)))
            ctrl_nx[B_RST] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= CTRL_RESET;
            mult_q   <= '0;
            pre_q    <= DIV_RESET;
            post_q   <= DIV_RESET;
            mult_chg <= 1'b0;
        end else begin
            mult_chg <= bus_wr && (bus_addr == A_MULT) && (bus_wdata[7:0] != mult_q);
            if (bus_wr) begin
                unique case (bus_addr)
                    A_CTRL:  ctrl_q <= ctrl_nx;
                    A_MULT:  mult_q <= bus_wdata[7:0];
                    A_PRE:   pre_q  <= bus_wdata & DMASK;
                    A_POST:  post_q <= bus_wdata & DMASK;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/pllc_lock.sv
module pllc_lock
    import pllc_pkg::*;
#(
    parameter int LOCK_CYCLES = 8000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd,
    input  logic hold,
    input  logic mult_chg,
    output logic lock
);
    localparam int CNT_W = $clog2(LOCK_CYCLES + 1);

    lk_state_e        state, state_n;
    logic [CNT_W-1:0] cnt;
    logic             restart;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LK_OFF;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        if (pd)
            state_n = LK_OFF;
        else if (hold)
            state_n = LK_HOLD;
        else begin
            unique case (state)
                LK_OFF, LK_HOLD: state_n = LK_ACQ;
                LK_ACQ:          if (!mult_chg && cnt == CNT_W'(LOCK_CYCLES - 1)) state_n = LK_LOCKED;
                LK_LOCKED:       if (mult_chg) state_n = LK_ACQ;
            endcase
        end
    end

    assign restart = (state_n == LK_ACQ) && ((state != LK_ACQ) || mult_chg);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt <= '0;
        else if (restart)          cnt <= '0;
        else if (state == LK_ACQ)  cnt <= cnt + 1'b1;
    end

    always_comb lock = (state == LK_LOCKED);
endmodule

// File: rtl/pllc_go.sv
module pllc_go
    import pllc_pkg::*;
#(
    parameter int NUM_OUT   = 4,
    parameter int RATIO_W   = 5,
    parameter int GO_CYCLES = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic [11:0]              bus_addr,
    input  logic [15:0]              bus_wdata,
    output logic                     busy,
    output logic [NUM_OUT*DIV_W-1:0] staged_flat,
    output logic [NUM_OUT*DIV_W-1:0] active_flat
);
    localparam int GC_W = $clog2(GO_CYCLES);
    localparam logic [15:0] DMASK = div_mask(RATIO_W);

    go_state_e       state, state_n;
    logic [GC_W-1:0] cnt;
    logic            go_req, launch, finish;

    assign go_req = bus_wr && (bus_addr == A_CMD) && bus_wdata[0];
    assign launch = (state == GO_IDLE) && go_req;
    assign finish = (state == GO_RUN) && (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= GO_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            GO_IDLE: if (go_req) state_n = GO_RUN;
            GO_RUN:  if (cnt == '0) state_n = GO_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (launch) cnt <= GC_W'(GO_CYCLES - 1);
        else if (state == GO_RUN) cnt <= cnt - 1'b1;
    end

    always_comb busy = (state == GO_RUN);

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
        logic [15:0] stg_q, pend_q, act_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg_q  <= DIV_RESET;
                pend_q <= DIV_RESET;
                act_q  <= DIV_RESET;
            end else begin
                if (bus_wr && bus_addr == out_addr(i)) stg_q <= bus_wdata & DMASK;
                if (launch) pend_q <= stg_q;
                if (finish) act_q  <= pend_q;
            end
        end
        assign staged_flat[i*DIV_W +: DIV_W] = stg_q;
        assign active_flat[i*DIV_W +: DIV_W] = act_q;
    end
endmodule

// File: rtl/pllc_top.sv
module pllc_top
    import pllc_pkg::*;
#(
    parameter int NUM_OUT     = 4,
    parameter int RATIO_W     = 5,
    parameter int GO_CYCLES   = 16,
    parameter int LOCK_CYCLES = 8000,
    parameter int BYPASS_MIN  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic [11:0]              bus_addr,
    input  logic [15:0]              bus_wdata,
    output logic [15:0]              bus_rdata,
    output logic                     pll_lock,
    output logic                     pll_selected,
    output logic                     go_busy,
    output logic [NUM_OUT*DIV_W-1:0] div_active
);
    logic [15:0]              ctrl_q, pre_q, post_q;
    logic [7:0]               mult_q;
    logic                     mult_chg;
    logic [NUM_OUT*DIV_W-1:0] staged_flat;

    pllc_regs #(.RATIO_W(RATIO_W), .BYPASS_MIN(BYPASS_MIN)) regs_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .ctrl_q(ctrl_q), .mult_q(mult_q),
        .pre_q(pre_q), .post_q(post_q), .mult_chg(mult_chg)
    );

    pllc_lock #(.LOCK_CYCLES(LOCK_CYCLES)) lock_i (
        .clk(clk), .rst_n(rst_n), .pd(ctrl_q[B_PD]),
        .hold(ctrl_q[B_RST] | ctrl_q[B_GATE]), .mult_chg(mult_chg),
        .lock(pll_lock)
    );

    pllc_go #(.NUM_OUT(NUM_OUT), .RATIO_W(RATIO_W), .GO_CYCLES(GO_CYCLES)) go_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .busy(go_busy), .staged_flat(staged_flat),
        .active_flat(div_active)
    );

    assign pll_selected = ctrl_q[B_EN] & pll_lock;

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRL:  bus_rdata = ctrl_q;
            A_MULT:  bus_rdata = {8'h00, mult_q};
            A_PRE:   bus_rdata = pre_q;
            A_POST:  bus_rdata = post_q;
            A_STAT:  bus_rdata = {15'h0000, go_busy};
            default: ;
        endcase
        for (int i = 0; i < NUM_OUT; i++)
            if (bus_addr == out_addr(i)) bus_rdata = staged_flat[i*DIV_W +: DIV_W];
    end
endmodule

// File: rtl/pllc_checker.sv
module pllc_checker #(
    parameter int ACT_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic [15:0]      ctrl_q,
    input logic             pll_lock,
    input logic             pll_selected,
    input logic             go_busy,
    input logic [ACT_W-1:0] div_active
);
    assert_reset_needs_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_q[3]) |-> !$past(ctrl_q[0]));

    assert_lock_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[3] || ctrl_q[1]) |=> !pll_lock);

    assert_select_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_selected) |-> pll_lock);

    assert_busy_lasts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(go_busy) |=> go_busy);

    assert_active_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(go_busy) |-> $stable(div_active));
endmodule

bind pllc_top pllc_checker #(.ACT_W(NUM_OUT*16)) chk_i (
    .clk(clk), .rst_n(rst_n), .ctrl_q(ctrl_q), .pll_lock(pll_lock),
    .pll_selected(pll_selected), .go_busy(go_busy), .div_active(div_active)
);

// File: tb/pllc_top_tb_top.sv
module pllc_top_tb_top;
    import pllc_pkg::*;

    localparam int NOUT = 4;
    localparam int RW   = 5;
    localparam int GOC  = 16;
    localparam int LOCKC = 8000;
    localparam logic [15:0] DM = 16'h801F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        pll_lock, pll_selected, go_busy;
    logic [NOUT*16-1:0] div_active;

    int errors = 0;
    int checks = 0;
    logic [15:0] stg_m [NOUT];
    logic [15:0] act_m [NOUT];
    logic [15:0] pend_m [NOUT];

    always #2 clk = ~clk;

    pllc_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pll_lock(pll_lock),
        .pll_selected(pll_selected), .go_busy(go_busy), .div_active(div_active)
    );

    function automatic logic [15:0] expect_div(input logic [15:0] v);
        return v & DM;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_lock(output int n);
        n = 0;
        while (!pll_lock && n < LOCKC + 20) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic check_active(input string req);
        for (int i = 0; i < NOUT; i++)
            chk(req, div_active[i*16 +: 16], act_m[i]);
    endtask

    // poke: 0 none, 1 second start command, 2 divider write, in busy cycle 3
    task automatic go_run(input int poke, input int pidx, input logic [15:0] pval);
        int n;
        logic [15:0] r;
        wr(A_CMD, 16'h0001);
        for (int i = 0; i < NOUT; i++) pend_m[i] = stg_m[i];
        n = 0;
        while (go_busy && n < 100) begin
            n++;
            if (n == 3 && poke != 0) begin
                bus_wr = 1'b1;
                bus_addr = (poke == 1) ? A_CMD : out_addr(pidx);
                bus_wdata = (poke == 1) ? 16'h0001 : pval;
                if (poke == 2) stg_m[pidx] = expect_div(pval);
            end else begin
                bus_wr = 1'b0;
            end
            @(negedge clk);
        end
        bus_wr = 1'b0;
        chk((poke == 1) ? "R9 busy length with repeated start" : "R8 busy length", n, GOC);
        for (int i = 0; i < NOUT; i++) act_m[i] = pend_m[i];
        check_active((poke == 2) ? "R10 active equals launch snapshot" : "R8 active after update");
        if (poke == 2) begin
            rd(out_addr(pidx), r);
            chk("R10 late write held in staging", r, stg_m[pidx]);
        end
        rd(A_STAT, r);
        chk("R8 status clear after update", r, 16'h0000);
    endtask

    initial begin
        logic [15:0] r;
        int n;
        void'($urandom(32'd1234));
        for (int i = 0; i < NOUT; i++) begin
            stg_m[i] = 16'h8000;
            act_m[i] = 16'h8000;
        end
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rd(A_CTRL, r); chk("R1 control reset", r, 16'h0012);
        rd(A_MULT, r); chk("R1 multiplier reset", r, 16'h0000);
        rd(A_STAT, r); chk("R1 status reset", r, 16'h0000);
        chk("R1 lock reset", pll_lock, 1'b0);
        chk("R1 select reset", pll_selected, 1'b0);
        chk("R1 busy reset", go_busy, 1'b0);
        check_active("R1 active divider reset");
        rd(out_addr(2), r); chk("R1 staged divider reset", r, 16'h8000);

        // R2 control field storage (enable long clear, reset bit accepted)
        wr(A_CTRL, 16'hFFFF);
        rd(A_CTRL, r); chk("R2 control mask", r, 16'h013B);
        wr(A_CTRL, 16'h0012);
        rd(A_CTRL, r); chk("R2 control rewrite", r, 16'h0012);

        // R3 reset guard
        wr(A_CTRL, 16'h0013);
        idle(2);
        wr(A_CTRL, 16'h0012);
        wr(A_CTRL, 16'h003A);
        rd(A_CTRL, r); chk("R3 early reset rejected", r, 16'h0032);
        idle(6);
        wr(A_CTRL, 16'h001A);
        rd(A_CTRL, r); chk("R3 reset accepted after settle", r, 16'h001A);

        // R4 lock acquisition
        wr(A_CTRL, 16'h0000);
        idle(LOCKC - 8);
        chk("R4 no lock before count", pll_lock, 1'b0);
        wait_lock(n);
        n = n + LOCKC - 8;
        chk("R4 lock time in window", (n >= LOCKC && n <= LOCKC + 2), 1'b1);
        chk("R6 bypass while enable clear", pll_selected, 1'b0);
        wr(A_CTRL, 16'h0001);
        chk("R6 select with enable and lock", pll_selected, 1'b1);

        // R5 multiplier: same value keeps lock, new value drops it
        wr(A_MULT, 16'h0000);
        idle(2);
        chk("R5 same multiplier keeps lock", pll_lock, 1'b1);
        wr(A_MULT, 16'h1FF);
        idle(2);
        chk("R5 multiplier change drops lock", pll_lock, 1'b0);
        chk("R6 bypass after lock loss", pll_selected, 1'b0);
        rd(A_MULT, r); chk("R7 multiplier low byte", r, 16'h00FF);
        wait_lock(n);
        chk("R4 relock after multiplier", pll_lock, 1'b1);
        wr(A_CTRL, 16'h0002);
        idle(2);
        chk("R5 power-down drops lock", pll_lock, 1'b0);
        wr(A_CTRL, 16'h0000);
        wait_lock(n);
        chk("R4 relock after power-down", pll_lock, 1'b1);
        wr(A_CTRL, 16'h0008);
        idle(2);
        chk("R5 loop reset drops lock", pll_lock, 1'b0);

        // R7 divider field masks
        wr(A_PRE, 16'hFFFF);
        rd(A_PRE, r); chk("R7 input divider mask", r, 16'h801F);
        wr(A_POST, 16'h7FE3);
        rd(A_POST, r); chk("R7 output divider mask", r, 16'h0003);

        // directed: plain update, repeated start, late write
        wr(out_addr(0), 16'h8004); stg_m[0] = expect_div(16'h8004);
        check_active("R11 staged write leaves active");
        go_run(0, 0, 16'h0);
        wr(out_addr(3), 16'h8011); stg_m[3] = expect_div(16'h8011);
        go_run(1, 0, 16'h0);
        go_run(2, 1, 16'hC00A);
        go_run(0, 0, 16'h0);

        // random mix
        for (int it = 0; it < 24; it++) begin
            int nw = $urandom_range(0, 3);
            for (int k = 0; k < nw; k++) begin
                int idx = $urandom_range(0, NOUT - 1);
                logic [15:0] v = 16'($urandom);
                wr(out_addr(idx), v);
                stg_m[idx] = expect_div(v);
                rd(out_addr(idx), r); chk("R7 staged readback", r, stg_m[idx]);
            end
            check_active("R11 active unchanged before start");
            go_run($urandom_range(0, 2), $urandom_range(0, NOUT - 1), 16'($urandom));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule